// File: doc/BRIEF.md
# Sensor Line and Frame Sync Generator

This block produces the horizontal and vertical drive pulses for an image sensor. It runs on the sensor's pixel clock, which is half the oscillator frequency. A pixel counter steps through each line and a line counter steps through each frame. The horizontal pulse sits at a fixed span of pixel positions at the start of every line. The vertical pulse is placed so that both of its edges land while the horizontal pulse is high.

The frame length depends on a mode input. Normal mode uses the longer frame and monitoring mode uses the shorter one. The mode input is sampled only on the last clock of a frame, and the new frame length starts when the line counter returns to line 1. A change of the mode input in the middle of a frame therefore does not affect that frame.

The current pixel and line counts are exported. A serial control writer can read the line count and keep its writes out of the forbidden window. A one-cycle strobe marks the first pixel of every frame. All outputs are plain control pins and have no handshake.

Top module: `scan_sync_gen`

## Requirements
- R1: `pix_cnt_o` runs from 0 to LINE_CLKS-1 (default 780 clocks per line). It goes up by one every clock and returns to 0 after LINE_CLKS-1.
- R2: `hsync_o` is 1 exactly when `pix_cnt_o` is in the range 0 to HS_LAST inclusive (default 78). Its falling edge therefore comes at the change from HS_LAST to HS_LAST+1.
- R3: `vsync_o` rises at pixel VS_CLK of line VS_LINE_ON (defaults 10 and 1). It falls at pixel VS_CLK of line VS_LINE_OFF (default 4). Every change of `vsync_o` happens in a cycle where `hsync_o` is 1.
- R4: `line_cnt_o` counts lines from 1 upward and holds its value within a line. It advances only on the clock after pixel LINE_CLKS-1, and it never leaves the range 1 to the frame length.
- R5: The frame length is NORM_LINES (default 525) when the latched mode is 0 and MON_LINES (default 262) when it is 1. `mon_mode_i` is latched only on the last clock of a frame (last pixel of the last line), and the new value applies from the following line 1. Changes of `mon_mode_i` at any other time have no effect on the current frame's length.
- R6: `frame_start_o` is 1 for exactly the one cycle in which `pix_cnt_o` is 0 and `line_cnt_o` is 1, and 0 in every other cycle.
- R7: While `rst_n` is 0, the outputs hold these values:
  - `pix_cnt_o` is 0 and `line_cnt_o` is 1;
  - `hsync_o` is 1, `vsync_o` is 0 and `frame_start_o` is 1;
  - the latched mode is 0 (normal), so the first frame after reset has NORM_LINES lines whatever `mon_mode_i` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mon_mode_i | input | 1 | Requested mode: 1 = monitoring (short frame), 0 = normal |
| hsync_o | output | 1 | Horizontal drive pulse |
| vsync_o | output | 1 | Vertical drive pulse |
| pix_cnt_o | output | $clog2(LINE_CLKS) | Pixel index within the current line |
| line_cnt_o | output | $clog2(max(NORM_LINES,MON_LINES)+1) | Line number within the current frame, starting at 1 |
| frame_start_o | output | 1 | One-cycle strobe at pixel 0 of line 1 |

## Verification
The checker runs every cycle. It checks:
- the stepping and range of the pixel counter;
- that the horizontal pulse matches its pixel window;
- that every vertical edge falls inside a horizontal high period, and that the vertical pulse is at its set level at each edge position;
- that the line counter holds within a line and steps at the end of a line;
- that the frame-start strobe matches the origin.

The checker cannot see the latched mode. So only the bench's scenarios show two things. First, the frame length follows `mon_mode_i` as it was on the final clock of the previous frame. Second, mode changes in the middle of a frame are ignored. To show this, the bench toggles the mode at times that do not line up with frame boundaries and compares every output against a model.

// File: rtl/sg_pkg.sv
package sg_pkg;

  typedef enum logic {
    MODE_NORMAL  = 1'b0,
    MODE_MONITOR = 1'b1
  } scan_mode_e;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sg_pix_ctr.sv
module sg_pix_ctr #(
  parameter int LINE_CLKS = 780,
  parameter int PIX_W     = $clog2(LINE_CLKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [PIX_W-1:0] pix_q,
  output logic [PIX_W-1:0] pix_n,
  output logic             eol
);

  localparam logic [PIX_W-1:0] LAST_PIX = PIX_W'(LINE_CLKS - 1);

  // End of line: the current clock is the last pixel of the line.
  assign eol = (pix_q == LAST_PIX);

  always_comb begin
    if (eol) pix_n = '0;
    else     pix_n = pix_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_q <= '0;
    else        pix_q <= pix_n;
  end

endmodule

// File: rtl/sg_line_ctr.sv
module sg_line_ctr
  import sg_pkg::*;
#(
  parameter int NORM_LINES = 525,
  parameter int MON_LINES  = 262,
  parameter int LINE_W     = $clog2(max_int(NORM_LINES, MON_LINES) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eol,
  input  logic              mon_mode_i,
  output logic [LINE_W-1:0] line_q,
  output logic [LINE_W-1:0] line_n
);

  localparam logic [LINE_W-1:0] NORM_LAST  = LINE_W'(NORM_LINES);
  localparam logic [LINE_W-1:0] MON_LAST   = LINE_W'(MON_LINES);
  localparam logic [LINE_W-1:0] FIRST_LINE = LINE_W'(1);

  scan_mode_e        mode_q;
  scan_mode_e        mode_n;
  logic [LINE_W-1:0] frame_last;
  logic              eof;

  assign frame_last = (mode_q == MODE_MONITOR) ? MON_LAST : NORM_LAST;

  // End of frame: last pixel of the last line of the current frame.
  assign eof = eol && (line_q == frame_last);

  always_comb begin
    line_n = line_q;
    mode_n = mode_q;
    if (eof) begin
      line_n = FIRST_LINE;
      // The mode is sampled here and nowhere else.
      mode_n = scan_mode_e'(mon_mode_i);
    end else if (eol) begin
      line_n = line_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= FIRST_LINE;
      mode_q <= MODE_NORMAL;
    end else begin
      line_q <= line_n;
      mode_q <= mode_n;
    end
  end

endmodule

// File: rtl/sg_pulse_dec.sv
module sg_pulse_dec #(
  parameter int PIX_W       = 10,
  parameter int LINE_W      = 10,
  parameter int HS_LAST     = 78,
  parameter int VS_CLK      = 10,
  parameter int VS_LINE_ON  = 1,
  parameter int VS_LINE_OFF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIX_W-1:0]  pix_n,
  input  logic [LINE_W-1:0] line_n,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              frame_start_o
);

  localparam logic [PIX_W-1:0]  HS_LAST_C = PIX_W'(HS_LAST);
  localparam logic [PIX_W-1:0]  VS_CLK_C  = PIX_W'(VS_CLK);
  localparam logic [LINE_W-1:0] VS_ON_C   = LINE_W'(VS_LINE_ON);
  localparam logic [LINE_W-1:0] VS_OFF_C  = LINE_W'(VS_LINE_OFF);
  localparam logic [LINE_W-1:0] ORIGIN_LN = LINE_W'(1);

  // Value of vsync at the origin (pixel 0, line 1), which is the reset position.
  localparam bit VS_AT_ORIGIN =
      ((1 > VS_LINE_ON)  || ((VS_LINE_ON == 1)  && (VS_CLK == 0))) &&
      ((1 < VS_LINE_OFF) || ((VS_LINE_OFF == 1) && (VS_CLK > 0)));

  logic hs_n;
  logic vs_after_on;
  logic vs_before_off;
  logic vs_n;
  logic fs_n;

  // The pulses are decoded from the next counter values and then registered,
  // so each output lines up with the count it describes and has no glitches.
  assign hs_n          = (pix_n <= HS_LAST_C);
  assign vs_after_on   = (line_n > VS_ON_C)  || ((line_n == VS_ON_C)  && (pix_n >= VS_CLK_C));
  assign vs_before_off = (line_n < VS_OFF_C) || ((line_n == VS_OFF_C) && (pix_n <  VS_CLK_C));
  assign vs_n          = vs_after_on && vs_before_off;
  assign fs_n          = (pix_n == '0) && (line_n == ORIGIN_LN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync_o       <= 1'b1;
      vsync_o       <= VS_AT_ORIGIN;
      frame_start_o <= 1'b1;
    end else begin
      hsync_o       <= hs_n;
      vsync_o       <= vs_n;
      frame_start_o <= fs_n;
    end
  end

endmodule

// File: rtl/scan_sync_gen.sv
module scan_sync_gen
  import sg_pkg::*;
#(
  parameter int LINE_CLKS   = 780,
  parameter int HS_LAST     = 78,
  parameter int NORM_LINES  = 525,
  parameter int MON_LINES   = 262,
  parameter int VS_CLK      = 10,
  parameter int VS_LINE_ON  = 1,
  parameter int VS_LINE_OFF = 4,
  localparam int PIX_W      = $clog2(LINE_CLKS),
  localparam int LINE_W     = $clog2(max_int(NORM_LINES, MON_LINES) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mon_mode_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic [PIX_W-1:0]  pix_cnt_o,
  output logic [LINE_W-1:0] line_cnt_o,
  output logic              frame_start_o
);

  logic [PIX_W-1:0]  pix_n;
  logic [LINE_W-1:0] line_n;
  logic              eol;

  sg_pix_ctr #(
    .LINE_CLKS (LINE_CLKS),
    .PIX_W     (PIX_W)
  ) u_pix (
    .clk   (clk),
    .rst_n (rst_n),
    .pix_q (pix_cnt_o),
    .pix_n (pix_n),
    .eol   (eol)
  );

  sg_line_ctr #(
    .NORM_LINES (NORM_LINES),
    .MON_LINES  (MON_LINES),
    .LINE_W     (LINE_W)
  ) u_line (
    .clk        (clk),
    .rst_n      (rst_n),
    .eol        (eol),
    .mon_mode_i (mon_mode_i),
    .line_q     (line_cnt_o),
    .line_n     (line_n)
  );

  sg_pulse_dec #(
    .PIX_W       (PIX_W),
    .LINE_W      (LINE_W),
    .HS_LAST     (HS_LAST),
    .VS_CLK      (VS_CLK),
    .VS_LINE_ON  (VS_LINE_ON),
    .VS_LINE_OFF (VS_LINE_OFF)
  ) u_dec (
    .clk           (clk),
    .rst_n         (rst_n),
    .pix_n         (pix_n),
    .line_n        (line_n),
    .hsync_o       (hsync_o),
    .vsync_o       (vsync_o),
    .frame_start_o (frame_start_o)
  );

endmodule

// File: rtl/sg_sync_chk.sv
module sg_sync_chk #(
  parameter int LINE_CLKS   = 780,
  parameter int HS_LAST     = 78,
  parameter int NORM_LINES  = 525,
  parameter int MON_LINES   = 262,
  parameter int VS_CLK      = 10,
  parameter int VS_LINE_ON  = 1,
  parameter int VS_LINE_OFF = 4,
  parameter int PIX_W       = 10,
  parameter int LINE_W      = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hsync_o,
  input logic              vsync_o,
  input logic [PIX_W-1:0]  pix_cnt_o,
  input logic [LINE_W-1:0] line_cnt_o,
  input logic              frame_start_o
);

  localparam logic [PIX_W-1:0]  LAST_PIX  = PIX_W'(LINE_CLKS - 1);
  localparam logic [PIX_W-1:0]  HS_LAST_C = PIX_W'(HS_LAST);
  localparam logic [PIX_W-1:0]  VS_CLK_C  = PIX_W'(VS_CLK);
  localparam logic [LINE_W-1:0] VS_ON_C   = LINE_W'(VS_LINE_ON);
  localparam logic [LINE_W-1:0] VS_OFF_C  = LINE_W'(VS_LINE_OFF);
  localparam logic [LINE_W-1:0] NORM_C    = LINE_W'(NORM_LINES);
  localparam logic [LINE_W-1:0] MON_C     = LINE_W'(MON_LINES);
  localparam logic [LINE_W-1:0] MAX_LN    = (NORM_C > MON_C) ? NORM_C : MON_C;
  localparam logic [LINE_W-1:0] ONE_LN    = LINE_W'(1);

  AST_PIX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_cnt_o <= LAST_PIX);  // R1
  AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_cnt_o != LAST_PIX) |=> (pix_cnt_o == $past(pix_cnt_o) + 1'b1));  // R1
  AST_PIX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_cnt_o == LAST_PIX) |=> (pix_cnt_o == '0));  // R1
  AST_HS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    hsync_o == (pix_cnt_o <= HS_LAST_C));  // R2
  AST_VS_EDGE_IN_HS: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vsync_o) || $fell(vsync_o)) |-> hsync_o);  // R3
  AST_VS_ON_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    ((line_cnt_o == VS_ON_C) && (pix_cnt_o == VS_CLK_C)) |-> vsync_o);  // R3
  AST_VS_OFF_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    ((line_cnt_o == VS_OFF_C) && (pix_cnt_o == VS_CLK_C)) |-> !vsync_o);  // R3
  AST_LINE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_cnt_o >= ONE_LN) && (line_cnt_o <= MAX_LN));  // R4
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_cnt_o != LAST_PIX) |=> $stable(line_cnt_o));  // R4
  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ((pix_cnt_o == LAST_PIX) && (line_cnt_o != NORM_C) && (line_cnt_o != MON_C))
      |=> (line_cnt_o == $past(line_cnt_o) + 1'b1));  // R5
  AST_FS_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o == ((pix_cnt_o == '0) && (line_cnt_o == ONE_LN)));  // R6
  AST_FS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |=> !frame_start_o);  // R6

endmodule

bind scan_sync_gen sg_sync_chk #(
  .LINE_CLKS   (LINE_CLKS),
  .HS_LAST     (HS_LAST),
  .NORM_LINES  (NORM_LINES),
  .MON_LINES   (MON_LINES),
  .VS_CLK      (VS_CLK),
  .VS_LINE_ON  (VS_LINE_ON),
  .VS_LINE_OFF (VS_LINE_OFF),
  .PIX_W       (PIX_W),
  .LINE_W      (LINE_W)
) u_sync_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .hsync_o       (hsync_o),
  .vsync_o       (vsync_o),
  .pix_cnt_o     (pix_cnt_o),
  .line_cnt_o    (line_cnt_o),
  .frame_start_o (frame_start_o)
);

// File: tb/scan_sync_gen_bench.sv
module scan_sync_gen_bench;

  localparam int B_LINE  = 16;
  localparam int B_HSL   = 4;
  localparam int B_NORM  = 7;
  localparam int B_MON   = 5;
  localparam int B_VSC   = 2;
  localparam int B_VON   = 1;
  localparam int B_VOFF  = 4;
  localparam int B_PW    = $clog2(B_LINE);
  localparam int B_LW    = $clog2(B_NORM + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              mon_mode = 1'b0;
  logic              hsync;
  logic              vsync;
  logic [B_PW-1:0]   pix;
  logic [B_LW-1:0]   line;
  logic              fs;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Model state: position after the latest edge, plus the latched mode.
  int  m_pix  = 0;
  int  m_line = 1;
  int  m_mode = 0;
  int  prev_vs = 0;
  int  run_len = 0;
  int  mon_frames = 0;

  always #5 clk = ~clk;

  scan_sync_gen #(
    .LINE_CLKS   (B_LINE),
    .HS_LAST     (B_HSL),
    .NORM_LINES  (B_NORM),
    .MON_LINES   (B_MON),
    .VS_CLK      (B_VSC),
    .VS_LINE_ON  (B_VON),
    .VS_LINE_OFF (B_VOFF)
  ) u_scan_sync_gen (
    .clk           (clk),
    .rst_n         (rst_n),
    .mon_mode_i    (mon_mode),
    .hsync_o       (hsync),
    .vsync_o       (vsync),
    .pix_cnt_o     (pix),
    .line_cnt_o    (line),
    .frame_start_o (fs)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (pix=%0d line=%0d)", req, act, exp, m_pix, m_line);
    end
  endtask

  function automatic int exp_vs(input int p, input int l);
    bit after_on, before_off;
    after_on   = (l > B_VON)  || ((l == B_VON)  && (p >= B_VSC));
    before_off = (l < B_VOFF) || ((l == B_VOFF) && (p <  B_VSC));
    return int'(after_on && before_off);
  endfunction

  task automatic check_all();
    chk("R1 pix", int'(pix), m_pix);
    chk("R4 line", int'(line), m_line);
    chk("R2 hsync", int'(hsync), int'(m_pix <= B_HSL));
    chk("R3 vsync", int'(vsync), exp_vs(m_pix, m_line));
    chk("R6 frame_start", int'(fs), int'(m_pix == 0 && m_line == 1));
    if (int'(vsync) != prev_vs) chk("R3 vsync edge inside hsync", int'(hsync), 1);
    prev_vs = int'(vsync);
  endtask

  // Advance the model by one clock, using the mode input seen at that edge.
  task automatic step_model(input int mode_at_edge);
    int last;
    last = (m_mode != 0) ? B_MON : B_NORM;
    if (m_pix == B_LINE - 1) begin
      m_pix = 0;
      if (m_line == last) begin
        // R5: frame length equals the mode that was latched for this frame
        chk("R5 frame length", m_line, (m_mode != 0) ? B_MON : B_NORM);
        if (m_mode != 0) mon_frames++;
        m_line = 1;
        m_mode = mode_at_edge;
      end else begin
        m_line = m_line + 1;
      end
    end else begin
      m_pix = m_pix + 1;
    end
  endtask

  task automatic run_cycles(input int n, input int toggle_every);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      step_model(int'(mon_mode));
      @(negedge clk);
      check_all();
      run_len++;
      if (toggle_every > 0 && (run_len % toggle_every) == 0) mon_mode = ~mon_mode;
    end
  endtask

  initial begin
    // R7: reset state, with the mode input requesting monitoring mode
    mon_mode = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 reset pix", int'(pix), 0);
    chk("R7 reset line", int'(line), 1);
    chk("R7 reset hsync", int'(hsync), 1);
    chk("R7 reset vsync", int'(vsync), 0);
    chk("R7 reset frame_start", int'(fs), 1);
    prev_vs = int'(vsync);
    rst_n = 1'b1;
    // R7: the first frame is normal length even with monitoring requested
    run_cycles(B_LINE * B_NORM, 0);
    chk("R7 first frame normal", int'(line), 1);
    // Monitoring held steady for several frames
    run_cycles(B_LINE * B_MON * 3, 0);
    // R5: drop the request mid-frame, then raise it again before the frame ends
    run_cycles(B_LINE * 2 + 3, 0);
    mon_mode = 1'b0;
    run_cycles(B_LINE, 0);
    mon_mode = 1'b1;
    run_cycles(B_LINE * 12, 0);
    // Toggle at a period unrelated to line and frame lengths
    mon_mode = 1'b0;
    run_cycles(1500, 23);
    run_cycles(700, 41);
    chk("R5 monitoring frames seen", int'(mon_frames >= 4), 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(150000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule